// File: doc/BRIEF.md
# Serial Flash Controller Host FIFO and Status Front End

This block sits between a host register port and the frame sequencer of a multi-lane serial flash controller. It keeps two byte FIFOs: one that carries bytes from the host to the sequencer for transmission, and one that carries bytes from the sequencer back to the host. The host reaches either FIFO through a byte-wide data port. When a configuration flag is set, it can also use a word-wide data port that moves four bytes per access in little-endian lane order.

A status word combines three kinds of bits. Some are sticky event bits that the host clears by writing ones. Some are live FIFO levels that the host can poll before each access. The rest are plain mirrors of the sequencer's ready signal and of the word-access flag. An enable register selects which of the low six status bits drive the single interrupt output.

Register accesses are single-cycle strobes. Read data appears in the registered `reg_rdata` in the cycle after the read strobe. Word addresses are 0 config (bit 0 is the word-access flag), 1 interrupt enable, 2 status, 3 receive byte, 4 transmit byte, 5 receive word and 6 transmit word.

Top module: `qspi_fifo_front`

## Requirements
- R1: After reset both FIFOs are empty, config, enable and sticky bits are zero, the status reads 0x018 with `seq_ready` low, and `irq` is low.
- R2: A write to the transmit byte port pushes `reg_wdata[7:0]` and ignores the upper bits. The sequencer sees the bytes at `seq_tx_data` in write order while `seq_tx_valid` is high, and pops one byte per `seq_tx_take`.
- R3: With the word-access flag set, a transmit word write pushes four bytes with bits 7:0 first. A receive word read pops four bytes and returns the oldest byte in bits 7:0.
- R4: A word access is ignored when the flag is clear. It is also ignored when fewer than four free slots (transmit) or four stored bytes (receive) exist. An ignored access returns zero and leaves the FIFO unchanged.
- R5: A byte write to a full FIFO is dropped, and a sequencer push into a full receive FIFO is dropped. A byte read from an empty receive FIFO returns zero.
- R6: Status bits that follow the current state: bit 3 is set while at least four transmit slots are free, bit 4 while the receive FIFO is empty, bit 5 while the transmit FIFO is full, bit 7 mirrors `seq_ready`, and bit 8 mirrors the word-access flag.
- R7: `seq_frame_end` sets status bits 0 (transmit done) and 1 (receive done). These bits stay set until the host writes a one to them at the status address. A set in the same cycle as a clear wins. Writing ones to bits 3 to 8 has no effect.
- R8: Status bit 2 sets when a byte enters an empty receive FIFO and is cleared by writing a one to it.
- R9: `irq` is high exactly when some status bit 0 to 5 is set together with the enable bit at the same position.
- R10: The interrupt enable register holds six bits at status positions 0 to 5 and reads back as written.
- R11: Each FIFO holds 32 bytes by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after `reg_rd` |
| irq | output | 1 | Interrupt request |
| seq_tx_valid | output | 1 | Transmit FIFO holds a byte |
| seq_tx_data | output | 8 | Oldest transmit byte |
| seq_tx_take | input | 1 | Sequencer pops one transmit byte |
| seq_rx_push | input | 1 | Sequencer pushes one receive byte |
| seq_rx_data | input | 8 | Receive byte from the sequencer |
| seq_frame_end | input | 1 | End-of-frame pulse |
| seq_ready | input | 1 | Sequencer idle and ready |

## Verification
A wrong pointer or count in either FIFO shows up within a few accesses. It appears as a byte out of order or missing at `seq_tx_data` or in a byte read, or as a live status level that disagrees with a fill count the bench tracks arithmetically across every fill level from 0 to 32. A wrong sticky or enable bit shows at the status read or at `irq` in the cycle after the event or write that caused it. All 64 enable patterns are swept against a known status so that a misrouted bit shows at once.

// File: rtl/qfe_pkg.sv
package qfe_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CFG  = 3'd0,
    A_IEN  = 3'd1,
    A_STAT = 3'd2,
    A_RXB  = 3'd3,
    A_TXB  = 3'd4,
    A_RXW  = 3'd5,
    A_TXW  = 3'd6
  } qfe_addr_e;

  // status bit positions (the host decodes these)
  localparam int ST_TXDONE  = 0;
  localparam int ST_RXDONE  = 1;
  localparam int ST_RXAVL   = 2;
  localparam int ST_TXROOM  = 3;
  localparam int ST_RXEMPTY = 4;
  localparam int ST_TXFULL  = 5;
  localparam int ST_READY   = 7;
  localparam int ST_WIDE    = 8;
  localparam int ST_W       = 9;
  localparam int EV_W       = 6;
  localparam int STICKY_W   = 3;
endpackage

// File: rtl/qfe_fifo.sv
module qfe_fifo #(
  parameter  int DEPTH    = 32,
  parameter  int LANES    = 4,
  parameter  int RD_LANES = 4,
  localparam int PW       = $clog2(DEPTH),
  localparam int CW       = PW + 1,
  localparam int NW       = $clog2(LANES) + 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NW-1:0]         push_n,
  input  logic [LANES*8-1:0]    push_data,
  input  logic [NW-1:0]         pop_n,
  output logic [RD_LANES*8-1:0] head,
  output logic [CW-1:0]         count
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          adv;

  always_comb begin
    adv   = (push_n != '0) || (pop_n != '0);
    wr_d  = wr_q + PW'(push_n);
    rd_d  = rd_q + PW'(pop_n);
    cnt_d = cnt_q + CW'(push_n) - CW'(pop_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else if (adv) begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int l = 0; l < LANES; l++) begin
      if (l < int'(push_n)) mem[wr_q + PW'(l)] <= push_data[8*l +: 8];
    end
  end

  for (genvar g = 0; g < RD_LANES; g++) begin : g_head
    assign head[8*g +: 8] = mem[rd_q + PW'(g)];
  end

  assign count = cnt_q;

  // the caller must never push past the free space
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(push_n) <= CW'(DEPTH) - cnt_q);
  p_no_underflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(pop_n) <= cnt_q);
  p_count_bound_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: rtl/qfe_status.sv
module qfe_status
  import qfe_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_end,
  input  logic                rx_arrive,
  input  logic                clr_we,
  input  logic [STICKY_W-1:0] clr_mask,
  input  logic                ien_we,
  input  logic [EV_W-1:0]     ien_wdata,
  input  logic                tx_room,
  input  logic                rx_empty,
  input  logic                tx_full,
  input  logic                ready,
  input  logic                wide,
  output logic [ST_W-1:0]     status,
  output logic [EV_W-1:0]     ien,
  output logic                irq
);
  logic [STICKY_W-1:0] sticky_q, sticky_d, set_v, clr_v;
  logic                sticky_en;
  logic [EV_W-1:0]     ien_q;

  always_comb begin
    set_v     = {rx_arrive, frame_end, frame_end};
    clr_v     = clr_we ? clr_mask : '0;
    sticky_en = clr_we || frame_end || rx_arrive;
    sticky_d  = (sticky_q & ~clr_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky_q <= '0;
    end else if (sticky_en) begin
      sticky_q <= sticky_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
    end else if (ien_we) begin
      ien_q <= ien_wdata;
    end
  end

  always_comb begin
    status             = '0;
    status[2:0]        = sticky_q;
    status[ST_TXROOM]  = tx_room;
    status[ST_RXEMPTY] = rx_empty;
    status[ST_TXFULL]  = tx_full;
    status[ST_READY]   = ready;
    status[ST_WIDE]    = wide;
    irq                = |(status[EV_W-1:0] & ien_q);
  end

  assign ien = ien_q;

  p_done_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> (sticky_q[ST_TXDONE] && sticky_q[ST_RXDONE]));
  p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sticky_q[ST_TXDONE] && !(clr_we && clr_mask[ST_TXDONE])) |=> sticky_q[ST_TXDONE]);
  p_avail_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_arrive |=> sticky_q[ST_RXAVL]);
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ien_q != '0));
endmodule

// File: rtl/qspi_fifo_front.sv
module qspi_fifo_front
  import qfe_pkg::*;
#(
  parameter  int DEPTH = 32,
  parameter  int LANES = 4,
  localparam int REG_W = LANES * 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              seq_tx_valid,
  output logic [7:0]        seq_tx_data,
  input  logic              seq_tx_take,
  input  logic              seq_rx_push,
  input  logic [7:0]        seq_rx_data,
  input  logic              seq_frame_end,
  input  logic              seq_ready
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam int NW = $clog2(LANES) + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] WIDE_CNT = CW'(LANES);

  qfe_addr_e        addr;
  logic             wide_q, wide_d, wide_en;
  logic [CW-1:0]    tx_cnt, rx_cnt, tx_free;
  logic [NW-1:0]    tx_push_n, tx_pop_n, rx_push_n, rx_pop_n;
  logic [7:0]       tx_head;
  logic [REG_W-1:0] rx_head, rx_in, rdata_d;
  logic             txb_ok, txw_ok, rxb_ok, rxw_ok, rx_arrive;
  logic [ST_W-1:0]  status;
  logic [EV_W-1:0]  ien;

  // access decode and FIFO gating
  always_comb begin
    addr      = qfe_addr_e'(reg_addr);
    tx_free   = FULL_CNT - tx_cnt;
    txb_ok    = reg_wr && (addr == A_TXB) && (tx_cnt != FULL_CNT);
    txw_ok    = reg_wr && (addr == A_TXW) && wide_q && (tx_free >= WIDE_CNT);
    rxb_ok    = reg_rd && (addr == A_RXB) && (rx_cnt != '0);
    rxw_ok    = reg_rd && (addr == A_RXW) && wide_q && (rx_cnt >= WIDE_CNT);
    tx_push_n = txw_ok ? NW'(LANES) : (txb_ok ? NW'(1) : '0);
    rx_pop_n  = rxw_ok ? NW'(LANES) : (rxb_ok ? NW'(1) : '0);
    tx_pop_n  = (seq_tx_take && (tx_cnt != '0)) ? NW'(1) : '0;
    rx_push_n = (seq_rx_push && (rx_cnt != FULL_CNT)) ? NW'(1) : '0;
    rx_in     = {{(REG_W-8){1'b0}}, seq_rx_data};
    rx_arrive = (rx_push_n != '0) && (rx_cnt == '0);
    wide_en   = reg_wr && (addr == A_CFG);
    wide_d    = reg_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wide_q <= 1'b0;
    end else if (wide_en) begin
      wide_q <= wide_d;
    end
  end

  qfe_fifo #(.DEPTH(DEPTH), .LANES(LANES), .RD_LANES(1)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .push_n(tx_push_n), .push_data(reg_wdata),
    .pop_n(tx_pop_n), .head(tx_head), .count(tx_cnt)
  );

  qfe_fifo #(.DEPTH(DEPTH), .LANES(LANES), .RD_LANES(LANES)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .push_n(rx_push_n), .push_data(rx_in),
    .pop_n(rx_pop_n), .head(rx_head), .count(rx_cnt)
  );

  qfe_status u_status (
    .clk(clk), .rst_n(rst_n),
    .frame_end(seq_frame_end), .rx_arrive(rx_arrive),
    .clr_we(reg_wr && (addr == A_STAT)), .clr_mask(reg_wdata[STICKY_W-1:0]),
    .ien_we(reg_wr && (addr == A_IEN)), .ien_wdata(reg_wdata[EV_W-1:0]),
    .tx_room(tx_free >= WIDE_CNT), .rx_empty(rx_cnt == '0),
    .tx_full(tx_cnt == FULL_CNT), .ready(seq_ready), .wide(wide_q),
    .status(status), .ien(ien), .irq(irq)
  );

  // read data selection, registered on the read strobe
  always_comb begin
    rdata_d = '0;
    case (addr)
      A_CFG:   rdata_d = {{(REG_W-1){1'b0}}, wide_q};
      A_IEN:   rdata_d = {{(REG_W-EV_W){1'b0}}, ien};
      A_STAT:  rdata_d = {{(REG_W-ST_W){1'b0}}, status};
      A_RXB:   rdata_d = rxb_ok ? {{(REG_W-8){1'b0}}, rx_head[7:0]} : '0;
      A_RXW:   rdata_d = rxw_ok ? rx_head : '0;
      default: rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rdata_d;
    end
  end

  assign seq_tx_valid = (tx_cnt != '0);
  assign seq_tx_data  = tx_head;

  p_wide_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (addr == A_RXW) && !wide_q) |=> (reg_rdata == '0));
  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && (addr == A_RXB) && (rx_cnt == '0)) |=> (reg_rdata == '0));
  p_tx_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_tx_valid && !reg_wr) |=> !seq_tx_valid);
endmodule

// File: tb/qspi_fifo_front_bench.sv
`timescale 1ns/1ps
module qspi_fifo_front_bench;
  localparam int D = 32;

  logic        clk, rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq, seq_tx_valid, seq_tx_take, seq_rx_push, seq_frame_end, seq_ready;
  logic [7:0]  seq_tx_data, seq_rx_data;

  int nvec = 0;
  int nbad = 0;

  qspi_fifo_front u_qspi_fifo_front (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .seq_tx_valid(seq_tx_valid), .seq_tx_data(seq_tx_data),
    .seq_tx_take(seq_tx_take), .seq_rx_push(seq_rx_push),
    .seq_rx_data(seq_rx_data), .seq_frame_end(seq_frame_end),
    .seq_ready(seq_ready)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [7:0] pat(int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic rx_push(logic [7:0] b);
    @(negedge clk);
    seq_rx_push = 1'b1; seq_rx_data = b;
    @(negedge clk);
    seq_rx_push = 1'b0;
  endtask

  task automatic tx_take(logic [7:0] exp, string tag);
    @(negedge clk);
    check({tag, " valid"}, 32'(seq_tx_valid), 32'd1);
    check({tag, " data"}, 32'(seq_tx_data), 32'(exp));
    seq_tx_take = 1'b1;
    @(negedge clk);
    seq_tx_take = 1'b0;
  endtask

  task automatic frame_end();
    @(negedge clk);
    seq_frame_end = 1'b1;
    @(negedge clk);
    seq_frame_end = 1'b0;
  endtask

  function automatic logic [31:0] word_of(int base);
    return {pat(base + 3), pat(base + 2), pat(base + 1), pat(base)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    seq_tx_take = 0; seq_rx_push = 0; seq_rx_data = 0;
    seq_frame_end = 0; seq_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd2, v); check("R1 status", v, 32'h018);
    rd(3'd0, v); check("R1 config", v, 32'h0);
    rd(3'd1, v); check("R1 enable", v, 32'h0);
    check("R1 irq", 32'(irq), 0);
    check("R1 tx empty", 32'(seq_tx_valid), 0);

    // R6 ready mirror
    seq_ready = 1'b1;
    rd(3'd2, v); check("R6 ready", v, 32'h098);

    // R2 R5 R6 R11: byte fill sweep over every level, 33rd write dropped
    for (int i = 0; i < D + 1; i++) begin
      int n;
      wr(3'd4, {24'hABCDEF, pat(i)});
      n = (i + 1 > D) ? D : i + 1;
      rd(3'd2, v);
      check("R6 live levels", v & 32'h38,
            {26'd0, (n == D), 1'b1, (D - n >= 4), 3'd0});
    end
    for (int i = 0; i < D; i++) tx_take(pat(i), "R2 R11 tx order");
    @(negedge clk); check("R5 full write dropped", 32'(seq_tx_valid), 0);

    // R3 word writes, R6 flag mirror
    wr(3'd0, 32'h1);
    rd(3'd2, v); check("R6 wide flag", v & 32'h100, 32'h100);
    for (int k = 0; k < D / 4; k++) wr(3'd6, word_of(4 * k + 50));
    wr(3'd6, 32'hDEADBEEF);
    for (int i = 0; i < D; i++) tx_take(pat(i + 50), "R3 tx word order");
    @(negedge clk); check("R4 word write into full dropped", 32'(seq_tx_valid), 0);

    // R4 word write with only three free slots
    for (int i = 0; i < D - 3; i++) wr(3'd4, {24'h0, pat(i + 90)});
    wr(3'd6, 32'h01020304);
    for (int i = 0; i < D - 3; i++) tx_take(pat(i + 90), "R4 tx short room");
    @(negedge clk); check("R4 short room no push", 32'(seq_tx_valid), 0);

    // R4 word write with flag clear
    wr(3'd0, 32'h0);
    wr(3'd6, 32'h11223344);
    @(negedge clk); check("R4 flag clear no push", 32'(seq_tx_valid), 0);

    // R2 R5 receive side byte reads
    for (int i = 0; i < D + 1; i++) rx_push(pat(i + 100));
    rd(3'd2, v); check("R6 rx not empty", v & 32'h10, 0);
    for (int i = 0; i < D; i++) begin
      rd(3'd3, v); check("R2 R5 rx byte", v, {24'h0, pat(i + 100)});
    end
    rd(3'd3, v); check("R5 empty read zero", v, 0);
    rd(3'd2, v); check("R6 rx empty", v & 32'h10, 32'h10);

    // R3 R4 receive word reads
    wr(3'd0, 32'h1);
    for (int i = 0; i < 8; i++) rx_push(pat(i + 150));
    rd(3'd5, v); check("R3 rx word 0", v, word_of(150));
    rd(3'd5, v); check("R3 rx word 1", v, word_of(154));
    for (int i = 0; i < 3; i++) rx_push(pat(i + 170));
    rd(3'd5, v); check("R4 rx word short", v, 0);
    for (int i = 0; i < 3; i++) begin
      rd(3'd3, v); check("R4 rx kept", v, {24'h0, pat(i + 170)});
    end
    wr(3'd0, 32'h0);
    for (int i = 0; i < 4; i++) rx_push(pat(i + 180));
    rd(3'd5, v); check("R4 rx word flag clear", v, 0);
    for (int i = 0; i < 4; i++) begin
      rd(3'd3, v); check("R4 rx kept flag clear", v, {24'h0, pat(i + 180)});
    end

    // R7 sticky done bits
    wr(3'd2, 32'h7);
    rd(3'd2, v); check("R7 cleared", v & 32'h7, 0);
    frame_end();
    rd(3'd2, v); check("R7 frame end sets", v & 32'h7, 32'h3);
    wr(3'd2, 32'h1);
    rd(3'd2, v); check("R7 w1c bit0 only", v & 32'h7, 32'h2);
    wr(3'd2, 32'h1F8);
    rd(3'd2, v); check("R7 live bits unaffected", v, 32'h09A);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h3; seq_frame_end = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; seq_frame_end = 1'b0;
    rd(3'd2, v); check("R7 set wins", v & 32'h3, 32'h3);
    wr(3'd2, 32'h7);

    // R8 receive available
    rx_push(8'h5A);
    rd(3'd2, v); check("R8 set on arrive", v & 32'h4, 32'h4);
    wr(3'd2, 32'h4);
    rd(3'd2, v); check("R8 w1c", v & 32'h4, 0);
    rx_push(8'h5B);
    rd(3'd2, v); check("R8 no set when non-empty", v & 32'h4, 0);
    rd(3'd3, v); rd(3'd3, v);
    rx_push(8'h5C);
    rd(3'd2, v); check("R8 set again", v & 32'h4, 32'h4);
    rd(3'd3, v);

    // R9 R10 enable sweep against status[5:0] = 0x1B
    frame_end();
    wr(3'd2, 32'h4);
    rd(3'd2, v); check("R9 known status", v & 32'h3F, 32'h1B);
    for (int e = 0; e < 64; e++) begin
      wr(3'd1, 32'(e));
      check("R9 irq", 32'(irq), 32'(((e & 32'h1B) != 0) ? 1 : 0));
      rd(3'd1, v); check("R10 enable readback", v, 32'(e));
    end
    wr(3'd1, 32'h3);
    wr(3'd2, 32'h3);
    @(negedge clk); check("R9 irq low", 32'(irq), 0);
    frame_end();
    check("R9 irq on frame end", 32'(irq), 1);
    wr(3'd2, 32'h3);
    check("R9 irq cleared", 32'(irq), 0);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule